// File: doc/BRIEF.md
# Dual-Clock Serial Field Memory

This block is a sequential-access buffer for one video line or field, written and read through two unrelated clocks. It has no full or empty flags and no address bus. Each side walks its own address pointer. A dedicated clear input returns that pointer to address zero, and the pointer wraps to zero after the last address. A producer clears the write pointer and then streams words in. A consumer clears the read pointer and streams the same words out, at its own pace and with its own pauses.

Each side has two qualifiers. A step input decides whether the pointer moves. A second input decides whether a word is actually transferred: on the write side it stores the word, and on the read side it drives the output. A write can therefore skip over stored words and leave them intact. A read can advance while the output is quiet. Data moves with a fixed two-cycle latency on both sides.

The buffer also checks a usage rule. After a pointer clear, at least a minimum number of active cycles must pass before the next clear on that side. If a clear comes too early, a sticky fault flag is raised for that side. The output bus stands in for a three-state pad: a separate drive-enable signal goes with it, and the bus reads zero whenever it is not driven.

Top module: `serial_field_buf`

## Requirements
- R1: While `rst_n` is low, `rdata_en`, `rdata`, `wr_fault` and `rd_fault` are all 0, and both pointers are at address 0.
- R2: `wptr_clr` high at a `wclk` edge sets the write pointer to 0. It overrides `wr_step`, and nothing is stored for that cycle.
- R3: With `wr_step` and `wr_load` both high at `wclk` edge k, the write pointer address A is captured, and the value on `wdata` at edge k+2 is stored at A. The pointer then advances by one, going from DEPTH-1 back to 0.
- R4: With `wr_step` high and `wr_load` low, the write pointer advances as in R3, and the word at the skipped address keeps its earlier contents.
- R5: With `wr_step` low and no clear, the write pointer holds and nothing is stored, whatever the value of `wr_load`.
- R6: `rptr_clr` high at an `rclk` edge sets the read pointer to 0. It overrides `rd_step`.
- R7: At every `rclk` edge k, the read pointer address A is sampled, and right after edge k+2 the word stored at A is presented. The pointer advances by one with wrap when `rd_step` is high and holds when it is low, so a halted pointer repeats its word.
- R8: `rdata_en` after edge k+2 equals `rd_show` at edge k. While `rdata_en` is 0, `rdata` is 0. `rd_show` has no effect on pointer movement.
- R9: An active cycle is `wr_step & wr_load` on the write side and `rd_step & rd_show` on the read side, in each case without a clear. A clear on a side sets that side's fault flag if that side has seen a previous clear since reset and fewer than MIN_RUN active cycles since it. Exactly MIN_RUN active cycles is legal. The flag stays set until `rst_n` goes low.
- R10: When a read samples an address at the same edge as a write commits to that address, the read returns the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of pointers, pipelines and fault flags |
| wclk | input | 1 | Write-side clock |
| wptr_clr | input | 1 | Write pointer clear to address 0 |
| wr_step | input | 1 | Write pointer advance |
| wr_load | input | 1 | Store the word for this step |
| wdata | input | DATA_W | Write data, sampled two edges after the step |
| wr_fault | output | 1 | Sticky flag for a write clear that came too early |
| rclk | input | 1 | Read-side clock |
| rptr_clr | input | 1 | Read pointer clear to address 0 |
| rd_step | input | 1 | Read pointer advance |
| rd_show | input | 1 | Drive the output for this cycle |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_en | output | 1 | Output drive enable |
| rd_fault | output | 1 | Sticky flag for a read clear that came too early |

## Verification
Two events can land on the same edge: a write committing to an address, and a read sampling that same address. This collision is forced by clearing both pointers on one edge and then stepping them together, so every write commit meets a read of the address being overwritten. The bench's model performs the read before the write at each edge and so expects the old word. The same lockstep run is then reused to place the clears at exactly MIN_RUN active cycles and at one cycle fewer, which tests the fault boundary on both sides at once.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_DEPTH   = 16;
    localparam int DEF_MIN_RUN = 231;

    function automatic int addr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sfb_ptr_step.sv
`timescale 1ns/1ps
module sfb_ptr_step #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam bit            POW2 = (DEPTH == (1 << AW));
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    generate
        if (POW2) begin : g_natural_wrap
            assign nxt = cur + 1'b1;
        end else begin : g_compare_wrap
            assign nxt = (cur == LAST) ? '0 : AW'(cur + 1'b1);
        end
    endgenerate
endmodule

// File: rtl/sfb_wr_port.sv
`timescale 1ns/1ps
module sfb_wr_port #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          load,
    output logic [AW-1:0] ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          active
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          v1;
        logic [AW-1:0] a1;
        logic          v2;
        logic [AW-1:0] a2;
    } wst_t;

    wst_t          st_d, st_q;
    logic [AW-1:0] ptr_inc;

    sfb_ptr_step #(.DEPTH(DEPTH), .AW(AW)) u_inc (
        .cur (st_q.ptr),
        .nxt (ptr_inc)
    );

    always_comb begin
        st_d    = st_q;
        st_d.v2 = st_q.v1;
        st_d.a2 = st_q.a1;
        st_d.a1 = st_q.ptr;
        if (clr) begin
            st_d.v1  = 1'b0;
            st_d.ptr = '0;
        end else begin
            st_d.v1 = step & load;
            if (step) begin
                st_d.ptr = ptr_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr       = st_q.ptr;
    assign mem_we    = st_q.v2;
    assign mem_waddr = st_q.a2;
    assign active    = step & load & ~clr;
endmodule

// File: rtl/sfb_rd_port.sv
`timescale 1ns/1ps
module sfb_rd_port #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          show,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] mem_raddr,
    output logic          drive,
    output logic          active
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          o1;
        logic [AW-1:0] a1;
        logic          o2;
        logic [AW-1:0] a2;
        logic          oe;
    } rst_t;

    rst_t          st_d, st_q;
    logic [AW-1:0] ptr_inc;

    sfb_ptr_step #(.DEPTH(DEPTH), .AW(AW)) u_inc (
        .cur (st_q.ptr),
        .nxt (ptr_inc)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = st_q.o2;
        st_d.o2 = st_q.o1;
        st_d.a2 = st_q.a1;
        st_d.o1 = show;
        st_d.a1 = st_q.ptr;
        if (clr) begin
            st_d.ptr = '0;
        end else if (step) begin
            st_d.ptr = ptr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr       = st_q.ptr;
    assign mem_raddr = st_q.a2;
    assign drive     = st_q.oe;
    assign active    = step & show & ~clr;
endmodule

// File: rtl/sfb_mem.sv
`timescale 1ns/1ps
module sfb_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AW     = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdout
);
    logic [DATA_W-1:0] rows [DEPTH];
    logic [DATA_W-1:0] dout_d, dout_q;

    generate
        for (genvar r = 0; r < DEPTH; r++) begin : g_row
            localparam logic [AW-1:0] ROW_ADDR = AW'(r);
            always_ff @(posedge wclk) begin
                if (we && (waddr == ROW_ADDR)) begin
                    rows[r] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        dout_d = rows[raddr];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_d;
        end
    end

    assign rdout = dout_q;
endmodule

// File: rtl/sfb_run_guard.sv
`timescale 1ns/1ps
module sfb_run_guard #(
    parameter int MIN_RUN = 231,
    parameter int CW      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    output logic fault
);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_RUN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          fault;
    } gst_t;

    gst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            if (st_q.armed && (st_q.cnt < LIMIT)) begin
                st_d.fault = 1'b1;
            end
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (active && (st_q.cnt < LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;
endmodule

// File: rtl/serial_field_buf.sv
`timescale 1ns/1ps
module serial_field_buf #(
    parameter int DATA_W  = sfb_pkg::DEF_DATA_W,
    parameter int DEPTH   = sfb_pkg::DEF_DEPTH,
    parameter int MIN_RUN = sfb_pkg::DEF_MIN_RUN
) (
    input  logic              rst_n,
    input  logic              wclk,
    input  logic              wptr_clr,
    input  logic              wr_step,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_fault,
    input  logic              rclk,
    input  logic              rptr_clr,
    input  logic              rd_step,
    input  logic              rd_show,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    output logic              rd_fault
);
    localparam int AW = sfb_pkg::addr_bits(DEPTH);
    localparam int CW = sfb_pkg::count_bits(MIN_RUN);

    logic [AW-1:0]     w_ptr, r_ptr;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic              w_active, r_active;
    logic              drive;
    logic [DATA_W-1:0] mem_dout;

    sfb_wr_port #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk       (wclk),
        .rst_n     (rst_n),
        .clr       (wptr_clr),
        .step      (wr_step),
        .load      (wr_load),
        .ptr       (w_ptr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .active    (w_active)
    );

    sfb_rd_port #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk       (rclk),
        .rst_n     (rst_n),
        .clr       (rptr_clr),
        .step      (rd_step),
        .show      (rd_show),
        .ptr       (r_ptr),
        .mem_raddr (mem_raddr),
        .drive     (drive),
        .active    (r_active)
    );

    sfb_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wdata),
        .rclk  (rclk),
        .rst_n (rst_n),
        .raddr (mem_raddr),
        .rdout (mem_dout)
    );

    sfb_run_guard #(.MIN_RUN(MIN_RUN), .CW(CW)) u_wguard (
        .clk    (wclk),
        .rst_n  (rst_n),
        .clr    (wptr_clr),
        .active (w_active),
        .fault  (wr_fault)
    );

    sfb_run_guard #(.MIN_RUN(MIN_RUN), .CW(CW)) u_rguard (
        .clk    (rclk),
        .rst_n  (rst_n),
        .clr    (rptr_clr),
        .active (r_active),
        .fault  (rd_fault)
    );

    assign rdata    = drive ? mem_dout : '0;
    assign rdata_en = drive;
endmodule

// File: rtl/sfb_checker.sv
`timescale 1ns/1ps
module sfb_checker #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input logic          rst_n,
    input logic          wclk,
    input logic          wptr_clr,
    input logic          wr_step,
    input logic [AW-1:0] w_ptr,
    input logic          wr_fault,
    input logic          rclk,
    input logic          rptr_clr,
    input logic          rd_step,
    input logic          rd_show,
    input logic [AW-1:0] r_ptr,
    input logic          rdata_en,
    input logic          rd_fault
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [1:0] seen;
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 2'd0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    assert_wclr_zero_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        wptr_clr |=> (w_ptr == '0));

    assert_wrap_step_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_step && !wptr_clr) |=>
            (w_ptr == (($past(w_ptr) == LAST) ? '0 : AW'($past(w_ptr) + 1'b1))));

    assert_whold_R5: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wr_step && !wptr_clr) |=> $stable(w_ptr));

    assert_rclr_zero_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        rptr_clr |=> (r_ptr == '0));

    assert_rhold_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_step && !rptr_clr) |=> $stable(r_ptr));

    assert_drive_latency_R8: assert property (@(posedge rclk) disable iff (!rst_n)
        (seen == 2'd3) |-> (rdata_en == $past(rd_show, 3)));

    assert_wfault_sticky_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_fault |=> wr_fault);

    assert_rfault_sticky_R9: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_fault |=> rd_fault);
endmodule

bind serial_field_buf sfb_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .rst_n    (rst_n),
    .wclk     (wclk),
    .wptr_clr (wptr_clr),
    .wr_step  (wr_step),
    .w_ptr    (w_ptr),
    .wr_fault (wr_fault),
    .rclk     (rclk),
    .rptr_clr (rptr_clr),
    .rd_step  (rd_step),
    .rd_show  (rd_show),
    .r_ptr    (r_ptr),
    .rdata_en (rdata_en),
    .rd_fault (rd_fault)
);

// File: tb/serial_field_buf_test.sv
`timescale 1ns/1ps
module serial_field_buf_test;
    localparam int W  = 16;
    localparam int D  = 16;
    localparam int MR = 231;

    logic         rst_n = 1'b0;
    logic         wclk = 1'b0, rclk = 1'b0;
    logic         wptr_clr = 1'b0, wr_step = 1'b0, wr_load = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         rptr_clr = 1'b0, rd_step = 1'b0, rd_show = 1'b0;
    logic [W-1:0] rdata;
    logic         rdata_en, wr_fault, rd_fault;

    int    tests = 0, fails = 0, gcyc = 0;
    bit    done = 1'b0;
    string cur = "R1";

    // bench-side expectation state
    logic [W-1:0] mm [D];
    int           wp, rp, wa1, wa2, ra1, ra2, wcnt, rcnt;
    bit           wv1, wv2, o1, o2, oeq, warm, rarm, wflt, rflt;
    logic [W-1:0] dq;

    always #2.5 wclk = ~wclk;
    always #2.5 rclk = ~rclk;

    serial_field_buf #(.DATA_W(W), .DEPTH(D), .MIN_RUN(MR)) uut (
        .rst_n(rst_n), .wclk(wclk), .wptr_clr(wptr_clr), .wr_step(wr_step),
        .wr_load(wr_load), .wdata(wdata), .wr_fault(wr_fault),
        .rclk(rclk), .rptr_clr(rptr_clr), .rd_step(rd_step), .rd_show(rd_show),
        .rdata(rdata), .rdata_en(rdata_en), .rd_fault(rd_fault)
    );

    function automatic logic [W-1:0] pat(input int n);
        return W'(n * 40503 + 467);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        wp = 0; rp = 0; wa1 = 0; wa2 = 0; ra1 = 0; ra2 = 0; wcnt = 0; rcnt = 0;
        wv1 = 0; wv2 = 0; o1 = 0; o2 = 0; oeq = 0; warm = 0; rarm = 0;
        wflt = 0; rflt = 0; dq = '0;
    endtask

    // one shared edge: the read samples memory before the write commits (R10)
    task automatic model_edge();
        dq  = mm[ra2];
        oeq = o2; o2 = o1; ra2 = ra1; o1 = rd_show; ra1 = rp;
        if (rptr_clr) begin
            if (rarm && rcnt < MR) rflt = 1;
            rcnt = 0; rarm = 1; rp = 0;
        end else begin
            if (rd_step && rd_show && rcnt < MR) rcnt++;
            if (rd_step) rp = (rp + 1) % D;
        end
        if (wv2) mm[wa2] = wdata;
        wv2 = wv1; wa2 = wa1;
        if (wptr_clr) begin
            if (warm && wcnt < MR) wflt = 1;
            wcnt = 0; warm = 1; wp = 0; wv1 = 0;
        end else begin
            wv1 = wr_step && wr_load;
            wa1 = wp;
            if (wr_step && wr_load && wcnt < MR) wcnt++;
            if (wr_step) wp = (wp + 1) % D;
        end
    endtask

    task automatic compare();
        logic [W-1:0] exp_d;
        exp_d = oeq ? dq : '0;
        chk(cur, "rdata_en", rdata_en, oeq);
        if (!(oeq && $isunknown(dq))) chk(cur, "rdata", rdata, exp_d);
        chk(cur, "wr_fault", wr_fault, wflt);
        chk(cur, "rd_fault", rd_fault, rflt);
    endtask

    task automatic cyc();
        @(posedge wclk);
        model_edge();
        @(negedge wclk);
        compare();
        gcyc++;
        wdata = pat(gcyc);
    endtask

    task automatic drive(input bit ws, input bit wl, input bit wc,
                         input bit rs, input bit rsh, input bit rc);
        wr_step = ws; wr_load = wl; wptr_clr = wc;
        rd_step = rs; rd_show = rsh; rptr_clr = rc;
        cyc();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge wclk);
        cur = "R1";
        chk(cur, "rdata_en in reset", rdata_en, 0);
        chk(cur, "rdata in reset", rdata, 0);
        chk(cur, "wr_fault in reset", wr_fault, 0);
        chk(cur, "rd_fault in reset", rd_fault, 0);
        rst_n = 1'b1;

        cur = "R2";   // clear wins over a raised step
        drive(1, 1, 1, 0, 0, 0);
        cur = "R3";   // fill every address several times over, wrapping
        for (int i = 0; i < 240; i++) drive(1, 1, 0, 0, 0, 0);
        cur = "R4";   // skip pattern keeps old words
        for (int i = 0; i < 40; i++) drive(1, (i % 3) != 0, 0, 0, 0, 0);
        cur = "R5";   // halted pointer, load toggling
        for (int i = 0; i < 30; i++) drive(0, i[0], 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);

        cur = "R6";
        drive(0, 0, 0, 1, 1, 1);
        cur = "R7";   // pauses repeat the word at the halted address
        for (int i = 0; i < 300; i++) drive(0, 0, 0, (i % 7) != 0, 1, 0);
        cur = "R8";   // quiet output while the pointer keeps moving
        for (int i = 0; i < 120; i++) drive(0, 0, 0, (i % 9) != 0, (i % 5) != 0, 0);

        cur = "R10";  // lockstep: each write commit meets a read of that address
        drive(0, 0, 1, 0, 1, 1);
        for (int i = 0; i < MR; i++) drive(1, 1, 0, 1, 1, 0);
        cur = "R9";   // exactly MR active cycles: legal
        drive(0, 0, 1, 0, 1, 1);
        chk("R9", "wr_fault at exact run", wr_fault, 0);
        chk("R9", "rd_fault at exact run", rd_fault, 0);
        for (int i = 0; i < MR - 1; i++) drive(1, 1, 0, 1, 1, 0);
        drive(0, 0, 1, 0, 1, 1);
        chk("R9", "wr_fault one short", wr_fault, 1);
        chk("R9", "rd_fault one short", rd_fault, 1);
        for (int i = 0; i < 5; i++) drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 1, 0, 0, 1);
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 0);
        chk("R9", "wr_fault sticky", wr_fault, 1);
        chk("R9", "rd_fault sticky", rd_fault, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule